// File: doc/BRIEF.md
# Bank Activation Window Scheduler

This block paces row activations across DRAM banks for processing elements that sit beside the sense amplifiers. A requester presents a bank and a row on a valid/ready handshake. The scheduler turns each accepted request into an activate command. It spaces activates by a minimum gap, and it never lets more than four of them fall inside a rolling four-activate window. The opened rows form an operand group of up to four distinct banks.

A group ends in one of two ways: the requester flags its last request, or a request arrives that cannot join (its bank is already open, or four banks are open). The scheduler then waits for the row-to-operation delay after the most recent activate. It broadcasts one operation code to every processing element, closes all open banks with a single precharge-all command, waits out the precharge time and pulses `done`. A second row of a bank that is already open is therefore fetched only after that close-out. All timing values are parameters, in clock cycles.

Top module: `actwin_sched`

## Requirements
- R1: After reset `cmd_type` is NOP (0), `done` is low, every command field is zero and `req_ready` is high.
- R2: `cmd_type` encodes NOP=0, ACT=1, PREA=2, OP=3. A handshake (`req_valid` and `req_ready` both high at a clock edge) produces ACT in the following cycle, carrying the request's bank and row. Outside ACT, bank and row read zero.
- R3: Two ACT commands are never closer than T_RRD cycles apart.
- R4: For any ACT and the fourth ACT after it, the later one is at least T_FAW cycles after the earlier, so no window of T_FAW cycles holds more than four.
- R5: `req_ready` is low for a bank already opened in the current group and whenever four banks are open. Presenting such a request while a group is open starts its close-out.
- R6: An accepted request with `req_last` high starts the close-out right after its ACT.
- R7: OP is issued in the first close-out cycle that is at least T_RCD cycles after the last ACT. It carries on `cmd_opc` the `req_opc` of the most recently accepted request. Outside OP, `cmd_opc` reads zero.
- R8: PREA follows OP in the very next cycle and is issued once per group.
- R9: `done` is high for exactly one cycle, T_RP cycles after PREA. `req_ready` stays low from the start of close-out until that pulse.
- R10: While collecting, a request that meets every rule of R3, R4 and R5 is accepted in the same cycle, and no command other than those in R2, R7 and R8 appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | $clog2(NUM_BANKS) | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_last | input | 1 | Final request of the operand group |
| req_opc | input | OPC_W | Operation code for the group |
| cmd_type | output | 2 | Command: 0 NOP, 1 ACT, 2 PREA, 3 OP |
| cmd_bank | output | $clog2(NUM_BANKS) | Bank of an ACT |
| cmd_row | output | ROW_W | Row of an ACT |
| cmd_opc | output | OPC_W | Operation code of an OP |
| done | output | 1 | One-cycle group completion pulse |

## Verification
The bench builds the block with eight banks, T_RRD=3, T_RCD=5, T_FAW=20 and T_RP=2. With four activates at the minimum gap spanning only 9 cycles, the four-activate window binds rather than the gap. With a short precharge time, the first activate of a new group lands inside the window opened by the previous group, so the window is exercised across a group boundary. Directed groups cover:
- a lone request,
- a full four-bank group,
- a repeated bank,
- five distinct banks with no last flag,
- idle gaps between requests.

A pseudo-random stream then mixes all of these cases.

// File: rtl/actwin_pkg.sv
package actwin_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_PREA = 2'd2,
    CMD_OP   = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_WAIT_RCD,
    ST_PRECHG,
    ST_RECOVER
  } state_e;
endpackage

// File: rtl/actwin_sat_cnt.sv
// Cycle counter that restarts at 1 and saturates at MAX.
module actwin_sat_cnt #(
  parameter int MAX      = 4,
  parameter int W        = $clog2(MAX + 1),
  parameter bit RST_FULL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    if (restart)              cnt_d = W'(1);
    else if (cnt == W'(MAX))  cnt_d = cnt;
    else                      cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= RST_FULL ? W'(MAX) : '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/actwin_faw_win.sv
// Ages of the most recent SLOTS activates; ok when the oldest is T_FAW old.
module actwin_faw_win #(
  parameter int SLOTS = 4,
  parameter int T_FAW = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  output logic ok
);
  localparam int AW = $clog2(T_FAW + 1);

  logic [AW-1:0]    age_q [SLOTS];
  logic [AW-1:0]    age_d [SLOTS];
  logic [SLOTS-1:0] vld_q, vld_d;

  function automatic logic [AW-1:0] age_inc(input logic [AW-1:0] a);
    return (a == AW'(T_FAW)) ? a : a + AW'(1);
  endfunction

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g == 0) begin : g_head
      always_comb begin
        age_d[g] = push ? AW'(1) : age_inc(age_q[g]);
        vld_d[g] = push | vld_q[g];
      end
    end else begin : g_tail
      always_comb begin
        age_d[g] = push ? age_inc(age_q[g-1]) : age_inc(age_q[g]);
        vld_d[g] = push ? vld_q[g-1] : vld_q[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age_q[g] <= '0;
      else        age_q[g] <= age_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign ok = !vld_q[SLOTS-1] || (age_q[SLOTS-1] == AW'(T_FAW));
endmodule

// File: rtl/actwin_bank_track.sv
// Open-bank set of the current operand group.
module actwin_bank_track #(
  parameter int NUM_BANKS = 8,
  parameter int MAX_OPEN  = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic              clr,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              hit,
  output logic              full,
  output logic              any
);
  localparam int CW = $clog2(MAX_OPEN + 1);

  logic [NUM_BANKS-1:0] mask_q, mask_d;
  logic [CW-1:0]        cnt_q, cnt_d;

  always_comb begin
    mask_d = mask_q;
    cnt_d  = cnt_q;
    if (clr) begin
      mask_d = '0;
      cnt_d  = '0;
    end else if (set) begin
      mask_d[bank_sel] = 1'b1;
      cnt_d            = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      cnt_q  <= '0;
    end else if (set || clr) begin
      mask_q <= mask_d;
      cnt_q  <= cnt_d;
    end
  end

  assign hit  = mask_q[bank_sel];
  assign full = (cnt_q == CW'(MAX_OPEN));
  assign any  = (cnt_q != '0);
endmodule

// File: rtl/actwin_sched.sv
module actwin_sched
  import actwin_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int OPC_W     = 4,
  parameter int MAX_OPEN  = 4,
  parameter int ACTS_WIN  = 4,
  parameter int T_FAW     = 20,
  parameter int T_RRD     = 4,
  parameter int T_RCD     = 6,
  parameter int T_RP      = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]             req_row,
  input  logic                         req_last,
  input  logic [OPC_W-1:0]             req_opc,
  output logic [1:0]                   cmd_type,
  output logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  output logic [ROW_W-1:0]             cmd_row,
  output logic [OPC_W-1:0]             cmd_opc,
  output logic                         done
);
  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int GAP_MAX = (T_RRD > T_RCD) ? T_RRD : T_RCD;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int RP_W    = $clog2(T_RP + 1);

  state_e              state_q, state_d;
  cmd_e                cmd_q, cmd_d;
  logic [BANK_W-1:0]   bank_q, bank_d;
  logic [ROW_W-1:0]    row_q, row_d;
  logic [OPC_W-1:0]    opo_q, opo_d;
  logic [OPC_W-1:0]    opc_q;
  logic                done_q, done_d;

  logic [GAP_W-1:0]    gap_cnt;
  logic [RP_W-1:0]     rp_cnt;
  logic                faw_ok, bank_hit, grp_full, grp_any;
  logic                can_act, accept, push, clr_all, rp_start;

  actwin_sat_cnt #(.MAX(GAP_MAX), .W(GAP_W), .RST_FULL(1'b1)) u_gap (
    .clk(clk), .rst_n(rst_n), .restart(push), .cnt(gap_cnt)
  );

  actwin_sat_cnt #(.MAX(T_RP), .W(RP_W), .RST_FULL(1'b0)) u_rp (
    .clk(clk), .rst_n(rst_n), .restart(rp_start), .cnt(rp_cnt)
  );

  actwin_faw_win #(.SLOTS(ACTS_WIN), .T_FAW(T_FAW)) u_faw (
    .clk(clk), .rst_n(rst_n), .push(push), .ok(faw_ok)
  );

  actwin_bank_track #(.NUM_BANKS(NUM_BANKS), .MAX_OPEN(MAX_OPEN), .BANK_W(BANK_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .set(push), .clr(clr_all), .bank_sel(req_bank),
    .hit(bank_hit), .full(grp_full), .any(grp_any)
  );

  assign can_act   = (gap_cnt >= GAP_W'(T_RRD)) && faw_ok && !bank_hit && !grp_full;
  assign req_ready = (state_q == ST_COLLECT) && can_act;
  assign accept    = req_valid && req_ready;

  // next-state and command selection
  always_comb begin
    state_d  = state_q;
    cmd_d    = CMD_NOP;
    bank_d   = '0;
    row_d    = '0;
    opo_d    = '0;
    done_d   = 1'b0;
    push     = 1'b0;
    clr_all  = 1'b0;
    rp_start = 1'b0;
    unique case (state_q)
      ST_COLLECT: begin
        if (accept) begin
          cmd_d  = CMD_ACT;
          bank_d = req_bank;
          row_d  = req_row;
          push   = 1'b1;
          if (req_last) state_d = ST_WAIT_RCD;
        end else if (req_valid && grp_any && (bank_hit || grp_full)) begin
          state_d = ST_WAIT_RCD;
        end
      end
      ST_WAIT_RCD: begin
        if (gap_cnt >= GAP_W'(T_RCD)) begin
          cmd_d   = CMD_OP;
          opo_d   = opc_q;
          state_d = ST_PRECHG;
        end
      end
      ST_PRECHG: begin
        cmd_d    = CMD_PREA;
        clr_all  = 1'b1;
        rp_start = 1'b1;
        state_d  = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (rp_cnt == RP_W'(T_RP)) begin
          done_d  = 1'b1;
          state_d = ST_COLLECT;
        end
      end
      default: state_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      cmd_q   <= CMD_NOP;
      bank_q  <= '0;
      row_q   <= '0;
      opo_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      bank_q  <= bank_d;
      row_q   <= row_d;
      opo_q   <= opo_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      opc_q <= '0;
    else if (accept) opc_q <= req_opc;
  end

  assign cmd_type = cmd_q;
  assign cmd_bank = bank_q;
  assign cmd_row  = row_q;
  assign cmd_opc  = opo_q;
  assign done     = done_q;
endmodule

// File: rtl/actwin_sched_chk.sv
module actwin_sched_chk #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int T_FAW     = 20,
  parameter int T_RRD     = 4,
  parameter int T_RCD     = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input logic [ROW_W-1:0]             req_row,
  input logic [1:0]                   cmd_type,
  input logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  input logic [ROW_W-1:0]             cmd_row,
  input logic                         done
);
  int                   cyc;
  int                   since;
  int                   act_n;
  int                   act_t [4];
  logic [NUM_BANKS-1:0] open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc    <= 0;
      since  <= 0;
      act_n  <= 0;
      open_q <= '0;
      for (int i = 0; i < 4; i++) act_t[i] <= 0;
    end else begin
      cyc <= cyc + 1;
      if (cmd_type == 2'd1) begin
        since    <= 1;
        act_t[0] <= cyc;
        for (int i = 1; i < 4; i++) act_t[i] <= act_t[i-1];
        if (act_n < 4) act_n <= act_n + 1;
        open_q[cmd_bank] <= 1'b1;
      end else begin
        if (since < 1000000) since <= since + 1;
        if (cmd_type == 2'd2) open_q <= '0;
      end
    end
  end

  assert_handshake_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_type == 2'd1 && cmd_bank == $past(req_bank) && cmd_row == $past(req_row)));

  assert_act_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_type == 2'd1 && act_n != 0) |-> (since >= T_RRD));

  assert_four_act_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_type == 2'd1 && act_n == 4) |-> (cyc - act_t[3] >= T_FAW));

  assert_bank_unique_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_type == 2'd1) |-> !open_q[cmd_bank]);

  assert_op_after_rcd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_type == 2'd3) |-> (act_n != 0 && since >= T_RCD));

  assert_prea_follows_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_type == 2'd3) |=> (cmd_type == 2'd2));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_closing_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_type == 2'd3 || cmd_type == 2'd2) |-> !req_ready);
endmodule

bind actwin_sched actwin_sched_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .T_FAW(T_FAW), .T_RRD(T_RRD), .T_RCD(T_RCD)
) u_chk (.*);

// File: tb/actwin_sched_bench.sv
module actwin_sched_bench;
  localparam int NB = 8, RW = 14, OW = 4, BW = 3;
  localparam int P_FAW = 20, P_RRD = 3, P_RCD = 5, P_RP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [BW-1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic          req_last = 1'b0;
  logic [OW-1:0] req_opc = '0;
  logic [1:0]    cmd_type;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [OW-1:0] cmd_opc;
  logic          done;

  always #2.5 clk = ~clk;

  actwin_sched #(
    .NUM_BANKS(NB), .ROW_W(RW), .OPC_W(OW), .MAX_OPEN(4), .ACTS_WIN(4),
    .T_FAW(P_FAW), .T_RRD(P_RRD), .T_RCD(P_RCD), .T_RP(P_RP)
  ) u_actwin_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_last(req_last), .req_opc(req_opc),
    .cmd_type(cmd_type), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_opc(cmd_opc),
    .done(done)
  );

  int total = 0, fails = 0;

  int q_idle[$], q_bank[$], q_row[$], q_last[$], q_opc[$];

  task automatic add(input int idle, input int b, input int r, input int l, input int o);
    q_idle.push_back(idle); q_bank.push_back(b); q_row.push_back(r);
    q_last.push_back(l); q_opc.push_back(o);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference model state
  int   cyc = 0;
  int   act_hist[$];
  int   last_act = -1000;
  int   phase = 0;
  int   prea_at = 0;
  bit   open_b[NB];
  int   open_n = 0;
  int   grp_opc = 0;
  string close_tag = "R6";
  logic [31:0] exp_cmd = '0;
  bit   exp_done = 1'b0;
  // observed-output bookkeeping
  int   obs_act[$];
  bit   obs_open[NB];
  int   obs_n = 0;
  int   idle_left = 0;
  int   drain = 0;

  initial begin
    // directed groups
    add(0, 2, 'h011, 1, 3);                       // lone request
    add(2, 0, 'h100, 0, 5); add(0, 1, 'h101, 0, 5);
    add(0, 2, 'h102, 0, 5); add(0, 3, 'h103, 1, 6); // four banks, opcode 6
    add(0, 4, 'h200, 1, 7);                       // window spans the group edge
    add(0, 1, 'h300, 0, 1); add(0, 5, 'h301, 0, 1);
    add(0, 1, 'h302, 1, 2);                       // repeated bank
    add(0, 0, 'h400, 0, 8); add(0, 3, 'h401, 0, 8); add(0, 5, 'h402, 0, 8);
    add(0, 6, 'h403, 0, 9); add(0, 7, 'h404, 1, 10); // five banks, no early last
    add(7, 2, 'h500, 0, 4); add(5, 6, 'h501, 1, 11); // idle gaps
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 60; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        add((lf[10:9] == 2'b11) ? int'(lf[12:11]) : 0, int'(lf[2:0]), int'(lf[15:2]),
            (i == 59 || lf[7:5] == 3'd0) ? 1 : 0, int'(lf[14:11]));
      end
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(cmd_type == 2'd0 && done == 1'b0 && cmd_bank == '0 && cmd_row == '0 && cmd_opc == '0,
        "R1", "reset outputs", {cmd_type, done}, 0);
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    idle_left = q_idle[0];

    while (drain < 12) begin
      logic [31:0] got;
      bit   can, rdy_exp, is_valid;
      int   b, d;
      if (cyc > 20000) begin
        chk(1'b0, "R10", "watchdog expired", cyc, 20000);
        break;
      end
      if (cyc != 0) @(negedge clk);
      d = cyc;

      // compare registered outputs decided in the previous cycle
      got = {9'd0, cmd_type, cmd_bank, cmd_row, cmd_opc};
      case (exp_cmd[22:21])
        2'd1: chk(got == exp_cmd, "R2", "ACT command", got, exp_cmd);
        2'd2: chk(got == exp_cmd, "R8", "PREA command", got, exp_cmd);
        2'd3: chk(got == exp_cmd, "R7", "OP command", got, exp_cmd);
        default: chk(got == exp_cmd, "R10", "idle command", got, exp_cmd);
      endcase
      chk(done == exp_done, "R9", "done pulse", done, exp_done);

      // independent checks on the observed command stream
      if (cmd_type == 2'd1) begin
        if (obs_act.size() > 0)
          chk(d - obs_act[obs_act.size()-1] >= P_RRD, "R3", "ACT spacing",
              d - obs_act[obs_act.size()-1], P_RRD);
        if (obs_act.size() >= 4)
          chk(d - obs_act[obs_act.size()-4] >= P_FAW, "R4", "four-ACT window",
              d - obs_act[obs_act.size()-4], P_FAW);
        chk(!obs_open[cmd_bank] && obs_n < 4, "R5", "bank open twice or group overfull",
            obs_n, 4);
        obs_act.push_back(d);
        obs_open[cmd_bank] = 1'b1;
        obs_n++;
      end else if (cmd_type == 2'd2) begin
        foreach (obs_open[i]) obs_open[i] = 1'b0;
        obs_n = 0;
      end

      // drive this cycle's request
      is_valid = (q_bank.size() > 0) && (idle_left == 0);
      if (q_bank.size() > 0) begin
        req_bank = BW'(q_bank[0]); req_row = RW'(q_row[0]);
        req_last = q_last[0][0];   req_opc = OW'(q_opc[0]);
      end
      req_valid = is_valid;
      if (q_bank.size() > 0 && idle_left > 0) idle_left--;
      #1;

      // reference model decision for this cycle
      b = int'(req_bank);
      can = (d - last_act >= P_RRD) &&
            (act_hist.size() < 4 || d - act_hist[act_hist.size()-4] >= P_FAW) &&
            !open_b[b] && open_n < 4;
      rdy_exp = (phase == 0) && can;
      if (phase != 0)            chk(req_ready == rdy_exp, "R9", "ready held low in close-out", req_ready, rdy_exp);
      else if (open_b[b] || open_n >= 4) chk(req_ready == rdy_exp, "R5", "ready for open bank", req_ready, rdy_exp);
      else if (!can)             chk(req_ready == rdy_exp, "R4", "ready under timing limits", req_ready, rdy_exp);
      else                       chk(req_ready == rdy_exp, "R10", "ready when allowed", req_ready, rdy_exp);

      exp_cmd  = '0;
      exp_done = 1'b0;
      case (phase)
        0: begin
          if (is_valid && can) begin
            exp_cmd = {9'd0, 2'd1, BW'(b), req_row, OW'(0)};
            act_hist.push_back(d);
            if (act_hist.size() > 4) void'(act_hist.pop_front());
            last_act  = d;
            open_b[b] = 1'b1;
            open_n++;
            grp_opc   = int'(req_opc);
            if (req_last) begin phase = 1; close_tag = "R6"; end
            void'(q_idle.pop_front()); void'(q_bank.pop_front()); void'(q_row.pop_front());
            void'(q_last.pop_front()); void'(q_opc.pop_front());
            idle_left = (q_idle.size() > 0) ? q_idle[0] : 0;
          end else if (is_valid && open_n > 0 && (open_b[b] || open_n >= 4)) begin
            phase = 1; close_tag = "R5";
          end
        end
        1: if (d - last_act >= P_RCD) begin
             exp_cmd = {9'd0, 2'd3, BW'(0), RW'(0), OW'(grp_opc)};
             phase = 2;
           end
        2: begin
          exp_cmd = {9'd0, 2'd2, BW'(0), RW'(0), OW'(0)};
          prea_at = d;
          foreach (open_b[i]) open_b[i] = 1'b0;
          open_n = 0;
          phase = 3;
        end
        default: if (d - prea_at == P_RP) begin
          exp_done = 1'b1;
          phase = 0;
        end
      endcase
      if (close_tag == "R5" && phase == 1 && exp_cmd == '0)
        chk(req_ready == 1'b0, "R5", "close-out after conflicting request", req_ready, 0);

      if (q_bank.size() == 0 && phase == 0 && !exp_done) drain++;
      cyc++;
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule